// File: doc/BRIEF.md
# Slave-mode DMA transfer controller

This block runs slave-mode DMA transfers on an asynchronous processor bus that has active-low read and write strobes. The same strobes carry register (PIO) accesses and DMA data beats. While chip select is asserted, a strobe goes to the register file. While a transfer is active and chip select is deasserted, it goes to the transfer engine, which counts one data item on each completed strobe. The external packet logic is represented only by an end-of-transfer input and a per-beat pulse output.

Software first loads a 32-bit item count one byte at a time. The three lower bytes are held in a staging register, and the whole count takes effect when the top byte is written. Software then issues a read or write command. A transfer stops for one of four reasons: the count runs out, end-of-transfer is signalled, a reset command arrives, or a stop command arrives. Each reason sets its own sticky flag. An interrupt line reports the flags that software has enabled.

Register map (byte addresses, 8-bit data): command at 0x230, count bytes at 0x234 (least significant) through 0x237 (most significant), configuration at 0x238, reason flags at 0x23C, enable mask at 0x23D. Other addresses read as zero.

Top module: `gdma_slave_ctrl`

## Requirements
- R1: Writing 0x00 to 0x230 starts a read transfer (dma_busy_o=1, dma_dir_o=0) that counts rd_ni beats. Writing 0x01 starts a write transfer (dma_dir_o=1) that counts wr_ni beats.
- R2: A strobe rising edge with cs_ni low is a register access. A rising edge of the direction's strobe with cs_ni high is a DMA beat only while busy. Strobes with cs_ni high while idle leave the count unchanged.
- R3: Writes to 0x234..0x236 go to staging only and do not change the count read back at 0x234..0x237. A write to 0x237 loads the 32-bit count {0x237,0x236,0x235,0x234}. That load is ignored while busy.
- R4: When configuration bit 0 is 0 (counter mode), each DMA beat decrements the count. The beat that brings it to 0 ends the transfer and sets reason bit 0 (count-complete).
- R5: A start command issued in counter mode with a count of 0 completes at once: reason bit 0 is set and dma_busy_o stays low.
- R6: eot_i high while busy ends the transfer and sets reason bit 1. If it coincides with the final counted beat, only bit 0 is set.
- R7: Opcode 0x0F while busy ends the transfer and sets reason bit 2, not bit 0. The remaining count is kept.
- R8: Opcode 0x0E while busy ends the transfer and sets reason bit 3.
- R9: With configuration bit 0 set, beats do not decrement the count and the transfer ends only through eot_i, stop or reset. Configuration writes are ignored while busy.
- R10: Writing 1s to 0x23C clears the matching reason bits. int_o is the OR of (reason AND mask at 0x23D).
- R11: After reset the block is idle with count, reasons, mask and configuration at 0, and int_o is low.
- R12: A start opcode issued while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Chip select for register access, active low |
| rd_ni | input | 1 | Read strobe, active low |
| wr_ni | input | 1 | Write strobe, active low |
| addr_i | input | 10 | Register byte address |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read data for addr_i |
| eot_i | input | 1 | End-of-transfer from the packet logic |
| dma_busy_o | output | 1 | Transfer active |
| dma_dir_o | output | 1 | 0 read, 1 write |
| dma_strobe_o | output | 1 | One-cycle pulse per DMA beat |
| int_o | output | 1 | Interrupt request |

## Verification
The bench checks that partial count writes stay invisible until the top byte is written, and that a top-byte write during a transfer is dropped. A design that loaded each byte directly would show a changed count early. A design that accepted the load mid-transfer would stretch the transfer. Each end cause is checked against its own flag. Coincident end-of-transfer and final beat must yield only count-complete, and a stop must not report completion, so a design with merged or misordered flags is caught. Three more corner cases are covered: a zero count must finish without entering the busy state, idle strobes must not decrement, and a masked flag must not raise the interrupt.

// File: rtl/gdma_pkg.sv
package gdma_pkg;
  localparam int unsigned ADDR_W = 10;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned CNT_W  = 32;
  localparam int unsigned NRSN   = 4;

  localparam logic [ADDR_W-1:0] A_CMD  = 10'h230;
  localparam logic [ADDR_W-1:0] A_CNT  = 10'h234;
  localparam logic [ADDR_W-1:0] A_CFG  = 10'h238;
  localparam logic [ADDR_W-1:0] A_RSN  = 10'h23C;
  localparam logic [ADDR_W-1:0] A_MSK  = 10'h23D;

  localparam logic [DATA_W-1:0] OP_RD   = 8'h00;
  localparam logic [DATA_W-1:0] OP_WR   = 8'h01;
  localparam logic [DATA_W-1:0] OP_RST  = 8'h0E;
  localparam logic [DATA_W-1:0] OP_STOP = 8'h0F;

  typedef enum int unsigned {
    RSN_DONE = 0,
    RSN_EOT  = 1,
    RSN_STOP = 2,
    RSN_RST  = 3
  } rsn_e;
endpackage

// File: rtl/gdma_strobe_steer.sv
module gdma_strobe_steer (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic rd_ni,
  input  logic wr_ni,
  input  logic xfer_active_i,
  input  logic xfer_dir_i,
  output logic pio_wr_o,
  output logic dma_beat_o
);
  logic cs_q, rd_q, wr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q <= 1'b1;
      rd_q <= 1'b1;
      wr_q <= 1'b1;
    end else begin
      cs_q <= cs_ni;
      rd_q <= rd_ni;
      wr_q <= wr_ni;
    end
  end

  logic rd_rise, wr_rise;
  assign rd_rise = !rd_q && rd_ni;
  assign wr_rise = !wr_q && wr_ni;

  // chip select low at strobe time steers to registers
  assign pio_wr_o   = !cs_q && wr_rise;
  assign dma_beat_o = xfer_active_i && cs_q && (xfer_dir_i ? wr_rise : rd_rise);
endmodule

// File: rtl/gdma_xfer_cnt.sv
module gdma_xfer_cnt #(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned BYTE_W = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     byte_we_i,
  input  logic [$clog2(CNT_W/BYTE_W)-1:0] byte_sel_i,
  input  logic [BYTE_W-1:0]        wdata_i,
  input  logic                     load_allow_i,
  input  logic                     dec_i,
  output logic [CNT_W-1:0]         cnt_o,
  output logic                     zero_o,
  output logic                     last_o
);
  localparam int unsigned NB    = CNT_W / BYTE_W;
  localparam int unsigned SEL_W = $clog2(NB);
  localparam logic [SEL_W-1:0] TOP = SEL_W'(NB - 1);

  logic [CNT_W-BYTE_W-1:0] stage_q;
  logic [CNT_W-1:0]        cnt_q;

  for (genvar g = 0; g < NB - 1; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[g*BYTE_W +: BYTE_W] <= '0;
      else if (byte_we_i && byte_sel_i == SEL_W'(g))
        stage_q[g*BYTE_W +: BYTE_W] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (byte_we_i && byte_sel_i == TOP && load_allow_i)
      cnt_q <= {wdata_i, stage_q};
    else if (dec_i && cnt_q != '0)
      cnt_q <= cnt_q - 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign zero_o = (cnt_q == '0);
  assign last_o = (cnt_q == CNT_W'(1));

  AST_STAGE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_we_i && byte_sel_i != TOP && !dec_i |=> $stable(cnt_o)); // R3
  AST_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zero_o && !byte_we_i |=> zero_o); // R4
endmodule

// File: rtl/gdma_irq.sv
module gdma_irq #(
  parameter int unsigned NRSN   = 4,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NRSN-1:0]   set_i,
  input  logic              clr_we_i,
  input  logic              mask_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [NRSN-1:0]   reason_o,
  output logic [NRSN-1:0]   mask_o,
  output logic              int_o
);
  logic [NRSN-1:0] reason_q, mask_q, clr;

  assign clr = clr_we_i ? wdata_i[NRSN-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reason_q <= '0;
      mask_q   <= '0;
    end else begin
      reason_q <= (reason_q & ~clr) | set_i;  // new events win over clear
      if (mask_we_i) mask_q <= wdata_i[NRSN-1:0];
    end
  end

  assign reason_o = reason_q;
  assign mask_o   = mask_q;
  assign int_o    = |(reason_q & mask_q);

  AST_W1C: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_we_i && set_i == '0 |=> (reason_o & $past(wdata_i[NRSN-1:0])) == '0); // R10
  AST_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_we_i |=> (($past(reason_o) & ~reason_o) == '0)); // R10
endmodule

// File: rtl/gdma_slave_ctrl.sv
module gdma_slave_ctrl
  import gdma_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              rd_ni,
  input  logic              wr_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              eot_i,
  output logic              dma_busy_o,
  output logic              dma_dir_o,
  output logic              dma_strobe_o,
  output logic              int_o
);
  localparam int unsigned NB    = CNT_W / DATA_W;
  localparam int unsigned SEL_W = $clog2(NB);

  logic busy_q, busy_d, dir_q, dir_d, cfg_dis_q;
  logic pio_wr, dma_beat;
  logic [CNT_W-1:0] cnt;
  logic cnt_zero, cnt_last;
  logic [NRSN-1:0] rsn_set, reason, mask;

  gdma_strobe_steer i_steer (
    .clk_i, .rst_ni, .cs_ni, .rd_ni, .wr_ni,
    .xfer_active_i (busy_q),
    .xfer_dir_i    (dir_q),
    .pio_wr_o      (pio_wr),
    .dma_beat_o    (dma_beat)
  );

  logic cmd_we, cnt_we, cfg_we, rsn_we, msk_we;
  assign cmd_we = pio_wr && addr_i == A_CMD;
  assign cnt_we = pio_wr && addr_i[ADDR_W-1:SEL_W] == A_CNT[ADDR_W-1:SEL_W];
  assign cfg_we = pio_wr && addr_i == A_CFG;
  assign rsn_we = pio_wr && addr_i == A_RSN;
  assign msk_we = pio_wr && addr_i == A_MSK;

  gdma_xfer_cnt #(.CNT_W(CNT_W), .BYTE_W(DATA_W)) i_cnt (
    .clk_i, .rst_ni,
    .byte_we_i    (cnt_we),
    .byte_sel_i   (addr_i[SEL_W-1:0]),
    .wdata_i,
    .load_allow_i (!busy_q),
    .dec_i        (dma_beat && !cfg_dis_q),
    .cnt_o        (cnt),
    .zero_o       (cnt_zero),
    .last_o       (cnt_last)
  );

  gdma_irq #(.NRSN(NRSN), .DATA_W(DATA_W)) i_irq (
    .clk_i, .rst_ni,
    .set_i     (rsn_set),
    .clr_we_i  (rsn_we),
    .mask_we_i (msk_we),
    .wdata_i,
    .reason_o  (reason),
    .mask_o    (mask),
    .int_o
  );

  logic final_beat;
  assign final_beat = dma_beat && !cfg_dis_q && cnt_last;

  always_comb begin
    busy_d  = busy_q;
    dir_d   = dir_q;
    rsn_set = '0;
    if (cmd_we) begin
      unique case (wdata_i)
        OP_RD, OP_WR: if (!busy_q) begin
          if (!cfg_dis_q && cnt_zero) rsn_set[RSN_DONE] = 1'b1;
          else begin
            busy_d = 1'b1;
            dir_d  = wdata_i[0];
          end
        end
        OP_STOP: if (busy_q) begin
          busy_d = 1'b0;
          rsn_set[RSN_STOP] = 1'b1;
        end
        OP_RST: if (busy_q) begin
          busy_d = 1'b0;
          rsn_set[RSN_RST] = 1'b1;
        end
        default: ;
      endcase
    end else if (busy_q) begin
      if (final_beat) begin
        busy_d = 1'b0;
        rsn_set[RSN_DONE] = 1'b1;
      end else if (eot_i) begin
        busy_d = 1'b0;
        rsn_set[RSN_EOT] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q    <= 1'b0;
      dir_q     <= 1'b0;
      cfg_dis_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      dir_q  <= dir_d;
      if (cfg_we && !busy_q) cfg_dis_q <= wdata_i[0];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i[ADDR_W-1:SEL_W] == A_CNT[ADDR_W-1:SEL_W])
      rdata_o = cnt[addr_i[SEL_W-1:0]*DATA_W +: DATA_W];
    else if (addr_i == A_CFG) rdata_o = DATA_W'(cfg_dis_q);
    else if (addr_i == A_RSN) rdata_o = DATA_W'(reason);
    else if (addr_i == A_MSK) rdata_o = DATA_W'(mask);
  end

  assign dma_busy_o   = busy_q;
  assign dma_dir_o    = dir_q;
  assign dma_strobe_o = dma_beat;

  AST_CNT_LIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && !cfg_dis_q |-> !cnt_zero); // R4
  AST_ZERO_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_we && (wdata_i == OP_RD || wdata_i == OP_WR) && !busy_q && !cfg_dis_q && cnt_zero
    |=> !busy_q && reason[RSN_DONE]); // R5
  AST_EOT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && eot_i && !cmd_we && !final_beat |=> !busy_q && reason[RSN_EOT]); // R6
  AST_STOP_ABORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && cmd_we && wdata_i == OP_STOP |=> !busy_q && reason[RSN_STOP]); // R7
  AST_RST_ABORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && cmd_we && wdata_i == OP_RST |=> !busy_q && reason[RSN_RST]); // R8
  AST_DIR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && $past(busy_q) |-> $stable(dir_q)); // R12
endmodule

// File: tb/test_gdma_slave_ctrl.sv
`timescale 1ns/1ps
module test_gdma_slave_ctrl;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic cs_ni = 1'b1, rd_ni = 1'b1, wr_ni = 1'b1, eot_i = 1'b0;
  logic [9:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic dma_busy_o, dma_dir_o, dma_strobe_o, int_o;

  always #4 clk = ~clk;

  gdma_slave_ctrl i_gdma_slave_ctrl (
    .clk_i(clk), .rst_ni, .cs_ni, .rd_ni, .wr_ni, .addr_i, .wdata_i,
    .rdata_o, .eot_i, .dma_busy_o, .dma_dir_o, .dma_strobe_o, .int_o
  );

  typedef struct { string tag; logic [31:0] exp; } exp_t;
  exp_t        exp_q[$];
  logic [31:0] act_q[$];
  int checks = 0, errors = 0;
  bit done = 0;

  // monitor: pops expected and observed items and compares
  always @(negedge clk) begin
    while (exp_q.size() > 0 && act_q.size() > 0) begin
      exp_t e;
      logic [31:0] a;
      e = exp_q.pop_front();
      a = act_q.pop_front();
      checks++;
      if (a !== e.exp) begin
        errors++;
        $display("FAIL %s actual=%0h expected=%0h", e.tag, a, e.exp);
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] exp, input logic [31:0] act);
    exp_q.push_back('{tag, exp});
    act_q.push_back(act);
  endtask

  task automatic pio_wr(input logic [9:0] a, input logic [7:0] d);
    @(negedge clk); cs_ni = 0; addr_i = a; wdata_i = d; wr_ni = 0;
    @(negedge clk); wr_ni = 1;
    @(negedge clk); cs_ni = 1;
  endtask

  task automatic pio_rd(input logic [9:0] a, output logic [7:0] d);
    @(negedge clk); cs_ni = 0; addr_i = a; rd_ni = 0;
    #1 d = rdata_o;
    @(negedge clk); rd_ni = 1;
    @(negedge clk); cs_ni = 1;
  endtask

  task automatic rd_cnt(output logic [31:0] c);
    for (int i = 0; i < 4; i++) begin
      logic [7:0] b;
      pio_rd(10'h234 + 10'(i), b);
      c[i*8 +: 8] = b;
    end
  endtask

  task automatic load(input logic [31:0] c);
    for (int i = 0; i < 4; i++) pio_wr(10'h234 + 10'(i), c[i*8 +: 8]);
  endtask

  task automatic beat(input bit wr);
    @(negedge clk); if (wr) wr_ni = 0; else rd_ni = 0;
    @(negedge clk); wr_ni = 1; rd_ni = 1;
    @(negedge clk);
  endtask

  task automatic pulse_eot();
    @(negedge clk); eot_i = 1;
    @(negedge clk); eot_i = 0;
  endtask

  logic [31:0] c;
  logic [7:0]  b;

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    // R11 reset state
    rd_cnt(c);            chk("R11 count", 0, c);
    pio_rd(10'h23C, b);   chk("R11 reason", 0, b);
    pio_rd(10'h23D, b);   chk("R11 mask", 0, b);
    chk("R11 busy/int", 0, {dma_busy_o, int_o});

    // R3 staging
    pio_wr(10'h234, 8'h03); pio_wr(10'h235, 8'h00); pio_wr(10'h236, 8'h00);
    rd_cnt(c);            chk("R3 staged not visible", 0, c);
    pio_wr(10'h237, 8'h00);
    rd_cnt(c);            chk("R3 load on top byte", 3, c);
    pio_wr(10'h23D, 8'h0F);

    // R2 idle strobes ignored
    beat(0); beat(1);
    rd_cnt(c);            chk("R2 idle strobes", 3, c);

    // R1 read transfer
    pio_wr(10'h230, 8'h00);
    chk("R1 read start", 2'b10, {dma_busy_o, dma_dir_o});
    beat(1);              // wrong direction strobe
    beat(0); beat(0);
    rd_cnt(c);            chk("R4 decrement per beat", 1, c);
    pio_wr(10'h237, 8'h05);
    rd_cnt(c);            chk("R3 load ignored while busy", 1, c);
    beat(0);
    pio_rd(10'h23C, b);   chk("R4 count done reason", 8'h01, b);
    chk("R4 idle int", 2'b01, {dma_busy_o, int_o});
    pio_wr(10'h23C, 8'h01);
    pio_rd(10'h23C, b);   chk("R10 w1c", 0, b);
    chk("R10 int low", 0, int_o);

    // write transfer ended by eot
    load(32'd2);
    pio_wr(10'h230, 8'h01);
    chk("R1 write start", 2'b11, {dma_busy_o, dma_dir_o});
    beat(1);
    rd_cnt(c);            chk("R1 write beat counted", 1, c);
    pulse_eot(); @(negedge clk);
    pio_rd(10'h23C, b);   chk("R6 eot reason", 8'h02, b);
    chk("R6 idle", 0, dma_busy_o);

    // R7 stop
    pio_wr(10'h230, 8'h00);
    pio_wr(10'h230, 8'h0F);
    pio_rd(10'h23C, b);   chk("R7 stop reason", 8'h06, b);
    rd_cnt(c);            chk("R7 count kept", 1, c);
    pio_wr(10'h23C, 8'h06);

    // R8 reset opcode
    pio_wr(10'h230, 8'h00);
    pio_wr(10'h230, 8'h0E);
    pio_rd(10'h23C, b);   chk("R8 reset reason", 8'h08, b);
    chk("R8 idle", 0, dma_busy_o);
    pio_wr(10'h23C, 8'h08);

    // R5 zero count
    load(32'd0);
    pio_wr(10'h230, 8'h00);
    chk("R5 stays idle", 0, dma_busy_o);
    pio_rd(10'h23C, b);   chk("R5 done reason", 8'h01, b);
    pio_wr(10'h23C, 8'h01);

    // R9 counter disabled
    pio_wr(10'h238, 8'h01);
    load(32'd1);
    pio_wr(10'h230, 8'h01);
    beat(1); beat(1);
    rd_cnt(c);            chk("R9 no decrement", 1, c);
    chk("R9 still busy", 1, dma_busy_o);
    pio_wr(10'h238, 8'h00);
    pio_rd(10'h238, b);   chk("R9 cfg write ignored while busy", 1, b);
    pulse_eot(); @(negedge clk);
    pio_rd(10'h23C, b);   chk("R9 eot ends", 8'h02, b);
    pio_wr(10'h238, 8'h00);
    pio_wr(10'h23C, 8'h02);

    // R6 coincident eot and final beat
    pio_wr(10'h230, 8'h00);
    @(negedge clk); rd_ni = 0;
    @(negedge clk); rd_ni = 1; eot_i = 1;
    @(negedge clk); eot_i = 0;
    pio_rd(10'h23C, b);   chk("R6 final beat wins", 8'h01, b);
    pio_wr(10'h23C, 8'h01);

    // R12 start while busy
    load(32'd2);
    pio_wr(10'h230, 8'h00);
    pio_wr(10'h230, 8'h01);
    chk("R12 direction kept", 2'b10, {dma_busy_o, dma_dir_o});
    beat(1);
    rd_cnt(c);            chk("R12 other strobe not counted", 2, c);
    pio_wr(10'h230, 8'h0F);
    pio_wr(10'h23C, 8'h0F);

    // R10 masked flag
    pio_wr(10'h23D, 8'h00);
    load(32'd0);
    pio_wr(10'h230, 8'h00);
    pio_rd(10'h23C, b);   chk("R10 flag set", 8'h01, b);
    chk("R10 masked int", 0, int_o);
    pio_wr(10'h23D, 8'h01);
    chk("R10 unmasked int", 1, int_o);

    repeat (4) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule